// File: doc/BRIEF.md
# Class-Pair Latency Interlock

This block sits at the issue stage of an in-order, single-issue pipeline. It decides whether the instruction now waiting to issue must be held back for another cycle. Each architectural register has a scoreboard entry. The entry records which class of instruction last wrote that register and how many cycles have passed since that writer issued. For each valid source operand, a fixed latency table is indexed by the producer class and the class of the waiting instruction. It gives the number of cycles that must lie between the two instructions. The stall output is high while any source still falls short of its gap.

The issue logic keeps the same candidate on the inputs while stall is high. The candidate issues in the first cycle where its class is not "none", stall is low and flush is low. An issuing instruction with a valid destination claims that register's entry. A flush empties the whole scoreboard, so that work fetched after it starts with no hazards.

Top module: `lat_interlock`

## Requirements
- R1: Synchronous active-high reset empties every scoreboard entry. After reset, stall is low for any candidate, including one whose sources were written before the reset.
- R2: A source written by an FP ALU operation (class 4) stalls a following FP ALU operation until 3 cycles lie between the two issues. That is 3 stall cycles when the consumer comes right after the producer.
- R3: A source written by an FP ALU operation stalls a following store-double (class 6) for 2 intervening cycles.
- R4: A source written by a load-double (class 5) stalls a following FP ALU operation for 1 intervening cycle. A store-double that reads it directly afterwards does not stall.
- R5: Integer producers have these gaps:
  - An integer-load result (class 2) needs 1 intervening cycle before any consuming class.
  - An integer-ALU result (class 1) needs 1 before an integer-ALU op or a branch (class 3), and 0 before any other class.
  - Every pair not named in R2 to R5 needs 0.
- R6: Stall is the OR over the source operands whose valid bit is set; an operand whose valid bit is clear is ignored.
  - Class codes: 0 none, 1 integer ALU, 2 integer load, 3 branch, 4 FP ALU, 5 load-double, 6 store-double.
  - A register id is 6 bits: bit 5 selects the FP file and bits 4:0 give the register number.
  - A candidate of class 0 never stalls.
- R7: Integer register 0 (id 0) never causes a stall and is never recorded as a destination.
- R8: A stalled candidate writes no entry. The elapsed counts of pending entries keep advancing through stalled and idle cycles, and the candidate's own destination is recorded only in the cycle it issues.
- R9: A newly issued producer replaces the entry of its destination register. Later consumers see only the newest producer's class and age.
- R10: The elapsed count saturates at the largest table latency (3) and never wraps. A producer that issued long ago causes no stall.
- R11: Flush clears all entries. The candidate presented in a flush cycle does not issue, and stall is low in the cycle after a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_class | input | 3 | Class code of the waiting instruction (0 = none) |
| src_valid | input | NUM_SRC | Per-operand valid bits |
| src_reg | input | NUM_SRC x 6 | Per-operand register ids |
| dst_valid | input | 1 | Candidate writes a destination register |
| dst_reg | input | 6 | Destination register id |
| flush | input | 1 | Discard pending producers and the current candidate |
| stall | output | 1 | Hold the candidate this cycle |

## Verification
The bench measures the exact number of stall cycles for each class pair in the table, including the zero-gap load-to-store pair. A design off by one in its age counter would show up as one stall too many or too few. It checks that a held candidate's destination is recorded only when it finally issues, since an early write would shorten the next consumer's wait. It also checks that an overwriting producer's class wins, that counters saturate instead of wrapping back into a stall, and that integer register 0 stays free. A flush test confirms that neither older producers nor the squashed candidate leave an entry behind, and a long random run compares stall against a behavioural model on every cycle.

// File: rtl/ilock_pkg.sv
package ilock_pkg;

    localparam int REG_NUM_W = 5;
    localparam int RID_W     = REG_NUM_W + 1;
    localparam int NUM_REGS  = 2 ** RID_W;
    localparam int MAX_LAT   = 3;
    localparam int CNT_W     = $clog2(MAX_LAT + 1);

    typedef enum logic [2:0] {
        CLS_NONE     = 3'd0,
        CLS_INT_ALU  = 3'd1,
        CLS_INT_LOAD = 3'd2,
        CLS_BRANCH   = 3'd3,
        CLS_FP_ALU   = 3'd4,
        CLS_LOAD_D   = 3'd5,
        CLS_STORE_D  = 3'd6
    } iclass_e;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [RID_W-1:0] rid_t;

    typedef struct packed {
        logic    busy;
        iclass_e cls;
        cnt_t    age;
    } sb_entry_t;

    // Required intervening cycles between producer and consumer classes.
    function automatic cnt_t req_gap(iclass_e prod, iclass_e cons);
        cnt_t g;
        g = '0;
        case (prod)
            CLS_FP_ALU: begin
                if (cons == CLS_FP_ALU)       g = cnt_t'(3);
                else if (cons == CLS_STORE_D) g = cnt_t'(2);
            end
            CLS_LOAD_D: begin
                if (cons == CLS_FP_ALU) g = cnt_t'(1);
            end
            CLS_INT_LOAD: begin
                if (cons != CLS_NONE) g = cnt_t'(1);
            end
            CLS_INT_ALU: begin
                if (cons == CLS_INT_ALU || cons == CLS_BRANCH) g = cnt_t'(1);
            end
            default: g = '0;
        endcase
        return g;
    endfunction

    // Integer register 0 is hard-wired and never tracked.
    function automatic logic is_hard_zero(rid_t r);
        return (r == '0);
    endfunction

endpackage

// File: rtl/ilock_scoreboard.sv
module ilock_scoreboard
    import ilock_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      wr_en,
    input  rid_t      wr_rid,
    input  iclass_e   wr_cls,
    output sb_entry_t entries [N_REGS]
);

    localparam cnt_t AGE_TOP = cnt_t'(MAX_LAT);

    for (genvar i = 0; i < N_REGS; i++) begin : g_entry
        sb_entry_t e;
        logic      hit;

        assign hit = wr_en && (wr_rid == rid_t'(i));

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                e.busy <= 1'b0;
                e.cls  <= CLS_NONE;
                e.age  <= '0;
            end else if (hit) begin
                e.busy <= 1'b1;
                e.cls  <= wr_cls;
                e.age  <= '0;
            end else if (e.busy && e.age != AGE_TOP) begin
                e.age  <= e.age + cnt_t'(1);
            end
        end

        assign entries[i] = e;

        AST_AGE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
            (e.busy && e.age != AGE_TOP && !flush && !hit) |=> (e.age == cnt_t'($past(e.age) + cnt_t'(1)))); // R8

        AST_AGE_SATURATES: assert property (@(posedge clk) disable iff (rst)
            (e.busy && e.age == AGE_TOP && !flush && !hit) |=> (e.busy && e.age == AGE_TOP)); // R10

        AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
            flush |=> !e.busy); // R11
    end

    AST_ZERO_NEVER_BUSY: assert property (@(posedge clk) disable iff (rst)
        !entries[0].busy); // R7

endmodule

// File: rtl/ilock_hazard_check.sv
module ilock_hazard_check
    import ilock_pkg::*;
#(
    parameter int N_SRC  = 2,
    parameter int N_REGS = NUM_REGS
) (
    input  iclass_e               cons_cls,
    input  logic [N_SRC-1:0]      src_valid,
    input  rid_t [N_SRC-1:0]      src_reg,
    input  sb_entry_t             entries [N_REGS],
    output logic                  stall
);

    logic [N_SRC-1:0] hit;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        sb_entry_t pe;
        cnt_t      need;

        assign pe   = entries[src_reg[s]];
        assign need = req_gap(pe.cls, cons_cls);

        always_comb begin
            hit[s] = src_valid[s]
                  && !is_hard_zero(src_reg[s])
                  && pe.busy
                  && (pe.age < need);
        end
    end

    assign stall = |hit;

endmodule

// File: rtl/lat_interlock.sv
module lat_interlock
    import ilock_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [2:0]                   cand_class,
    input  logic [NUM_SRC-1:0]           src_valid,
    input  logic [NUM_SRC-1:0][RID_W-1:0] src_reg,
    input  logic                         dst_valid,
    input  logic [RID_W-1:0]             dst_reg,
    input  logic                         flush,
    output logic                         stall
);

    iclass_e   cls;
    logic      wr_en;
    sb_entry_t entries [NUM_REGS];
    rid_t [NUM_SRC-1:0] srcs;

    assign cls  = iclass_e'(cand_class);
    assign srcs = src_reg;

    assign wr_en = (cls != CLS_NONE) && dst_valid && !stall && !flush
                && !is_hard_zero(dst_reg);

    ilock_scoreboard #(
        .N_REGS (NUM_REGS)
    ) u_sb (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_rid  (dst_reg),
        .wr_cls  (cls),
        .entries (entries)
    );

    ilock_hazard_check #(
        .N_SRC  (NUM_SRC),
        .N_REGS (NUM_REGS)
    ) u_chk (
        .cons_cls  (cls),
        .src_valid (src_valid),
        .src_reg   (srcs),
        .entries   (entries),
        .stall     (stall)
    );

    AST_FLUSH_FREES: assert property (@(posedge clk) disable iff (rst)
        flush |=> !stall); // R11

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (cand_class == 3'd0) |-> !stall); // R6

    AST_NO_VALID_SRC: assert property (@(posedge clk) disable iff (rst)
        (src_valid == '0) |-> !stall); // R6

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (rst || !stall)); // R1

endmodule

// File: tb/lat_interlock_test.sv
module lat_interlock_test;

    localparam int CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      cand_class = '0;
    logic [1:0]      src_valid = '0;
    logic [1:0][5:0] src_reg = '0;
    logic            dst_valid = 1'b0;
    logic [5:0]      dst_reg = '0;
    logic            flush = 1'b0;
    logic            stall;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    bit mvld [64];
    int mcls [64];
    int mcyc [64];

    always #(CLK_P/2) clk = ~clk;

    lat_interlock #(.NUM_SRC(2)) uut (
        .clk(clk), .rst(rst), .cand_class(cand_class), .src_valid(src_valid),
        .src_reg(src_reg), .dst_valid(dst_valid), .dst_reg(dst_reg),
        .flush(flush), .stall(stall)
    );

    function automatic int gap(int p, int c);
        if (p == 4 && c == 4) return 3;
        if (p == 4 && c == 6) return 2;
        if (p == 5 && c == 4) return 1;
        if (p == 2 && c != 0) return 1;
        if (p == 1 && (c == 1 || c == 3)) return 1;
        return 0;
    endfunction

    function automatic bit model_stall(int c, bit v0, int r0, bit v1, int r1);
        bit st = 0;
        if (v0 && r0 != 0 && mvld[r0] && (cyc - mcyc[r0] - 1) < gap(mcls[r0], c)) st = 1;
        if (v1 && r1 != 0 && mvld[r1] && (cyc - mcyc[r1] - 1) < gap(mcls[r1], c)) st = 1;
        return st;
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 64; i++) mvld[i] = 0;
    endtask

    // One cycle: drive, compare stall against model, update model.
    task automatic step(string tag, int c, bit v0, int r0, bit v1, int r1,
                        bit dv, int d, bit fl, output bit obs);
        bit e;
        @(negedge clk);
        cand_class   = 3'(c);
        src_valid[0] = v0;  src_reg[0] = 6'(r0);
        src_valid[1] = v1;  src_reg[1] = 6'(r1);
        dst_valid    = dv;  dst_reg    = 6'(d);
        flush        = fl;
        #1;
        e = model_stall(c, v0, r0, v1, r1);
        chk(tag, int'(stall), int'(e));
        obs = stall;
        if (fl) clear_model();
        else if (c != 0 && !e && dv && d != 0) begin
            mvld[d] = 1; mcls[d] = c; mcyc[d] = cyc;
        end
        cyc++;
    endtask

    task automatic idle(int n);
        bit o;
        for (int i = 0; i < n; i++) step("IDLE", 0, 0, 0, 0, 0, 0, 0, 0, o);
    endtask

    // Present a candidate until it issues; check number of stall cycles.
    task automatic wait_issue(string tag, int c, bit v0, int r0, bit v1, int r1,
                              bit dv, int d, int exp_stalls);
        bit o;
        int n = 0;
        o = 1;
        while (o && n < 10) begin
            step(tag, c, v0, r0, v1, r1, dv, d, 0, o);
            if (o) n++;
        end
        chk(tag, n, exp_stalls);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; cand_class = 0; src_valid = 0; dst_valid = 0; flush = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        clear_model();
        cyc++;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit o;
        clear_model();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: clean after reset
        step("R1", 4, 1, 33, 1, 34, 0, 0, 0, o);
        chk("R1", int'(o), 0);

        // R2: FP ALU -> FP ALU, 3
        wait_issue("R2", 4, 0, 0, 0, 0, 1, 32+2, 0);
        wait_issue("R2", 4, 1, 32+2, 0, 0, 1, 32+4, 3);

        // R3: FP ALU -> store double, 2
        wait_issue("R3", 4, 0, 0, 0, 0, 1, 32+3, 0);
        wait_issue("R3", 6, 1, 32+3, 1, 1, 0, 0, 2);

        // R4: load double -> FP ALU 1, -> store double 0
        wait_issue("R4", 5, 0, 0, 1, 1, 1, 32+6, 0);
        wait_issue("R4", 4, 1, 32+6, 0, 0, 1, 32+20, 1);
        wait_issue("R4", 5, 0, 0, 1, 1, 1, 32+7, 0);
        wait_issue("R4", 6, 1, 32+7, 0, 0, 0, 0, 0);

        // R5: integer pairs
        wait_issue("R5", 2, 0, 0, 0, 0, 1, 5, 0);
        wait_issue("R5", 1, 1, 5, 0, 0, 1, 9, 1);
        wait_issue("R5", 1, 0, 0, 0, 0, 1, 6, 0);
        wait_issue("R5", 3, 1, 6, 0, 0, 0, 0, 1);
        wait_issue("R5", 1, 0, 0, 0, 0, 1, 7, 0);
        wait_issue("R5", 6, 1, 7, 0, 0, 0, 0, 0);
        wait_issue("R5", 1, 0, 0, 0, 0, 1, 8, 0);
        wait_issue("R5", 1, 0, 0, 1, 8, 1, 10, 1);

        // R6: invalid operand ignored; class none never stalls
        wait_issue("R6", 4, 0, 0, 0, 0, 1, 32+9, 0);
        step("R6", 4, 0, 32+9, 0, 32+9, 0, 0, 0, o);
        chk("R6", int'(o), 0);
        step("R6", 0, 1, 32+9, 1, 32+9, 0, 0, 0, o);
        chk("R6", int'(o), 0);
        idle(4);

        // R7: integer r0 never stalls
        wait_issue("R7", 2, 0, 0, 0, 0, 1, 0, 0);
        wait_issue("R7", 1, 1, 0, 1, 0, 1, 11, 0);

        // R8: stalled candidate records dest only at issue; ages advance
        wait_issue("R8", 4, 0, 0, 0, 0, 1, 32+10, 0);
        wait_issue("R8", 4, 1, 32+10, 0, 0, 1, 32+11, 3);
        wait_issue("R8", 4, 1, 32+11, 0, 0, 0, 0, 3);
        wait_issue("R8", 4, 0, 0, 0, 0, 1, 32+12, 0);
        idle(1);
        wait_issue("R8", 4, 0, 0, 1, 32+12, 0, 0, 2);

        // R9: newer producer overwrites
        wait_issue("R9", 4, 0, 0, 0, 0, 1, 32+13, 0);
        wait_issue("R9", 5, 0, 0, 0, 0, 1, 32+13, 0);
        wait_issue("R9", 4, 1, 32+13, 0, 0, 0, 0, 1);

        // R10: saturation, no wrap
        wait_issue("R10", 4, 0, 0, 0, 0, 1, 32+14, 0);
        idle(9);
        wait_issue("R10", 4, 1, 32+14, 0, 0, 0, 0, 0);

        // R11: flush clears, flush-cycle candidate squashed
        wait_issue("R11", 4, 0, 0, 0, 0, 1, 32+15, 0);
        step("R11", 4, 0, 0, 0, 0, 1, 32+16, 1, o);
        wait_issue("R11", 4, 1, 32+15, 0, 0, 0, 0, 0);
        wait_issue("R11", 4, 1, 32+16, 0, 0, 0, 0, 0);

        // R1: reset clears pending producers
        wait_issue("R1", 4, 0, 0, 0, 0, 1, 32+17, 0);
        do_reset();
        wait_issue("R1", 4, 1, 32+17, 0, 0, 0, 0, 0);

        // Random traffic over a small register set against the model
        for (int k = 0; k < 4000; k++) begin
            int c, r0, r1, d;
            bit v0, v1, dv, fl;
            c  = $urandom_range(0, 6);
            r0 = ($urandom_range(0, 1) * 32) + $urandom_range(0, 3);
            r1 = ($urandom_range(0, 1) * 32) + $urandom_range(0, 3);
            d  = ($urandom_range(0, 1) * 32) + $urandom_range(0, 3);
            v0 = 1'($urandom_range(0, 1));
            v1 = 1'($urandom_range(0, 1));
            dv = 1'($urandom_range(0, 1));
            fl = ($urandom_range(0, 24) == 0);
            step("R8", c, v0, r0, v1, r1, dv, d, fl, o);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule